// File: doc/BRIEF.md
# Switched-Power Ratio Statistics Engine

The block gathers one-second statistics from two independent streams of signed 16-bit log-power detector samples, each arriving at about 4 kHz with a valid strobe. For every channel it sums the samples and their squares over a window whose length is a programmable number of accepted samples. When the window closes it reports the mean of the series (total power in converter units), its population standard deviation, and a switched-power ratio.

A calibration noise diode switched as a 50% duty-cycle square wave adds a step to the detected log-power. The step amplitude is twice the standard deviation of the series, so it is found statistically instead of by synchronous on/off demodulation. Because the detector output is linear in dB, the ratio is the standard deviation times one fixed-point constant. That constant folds in ln(10), the factor of two, the converter volts per level and the detector volts per power unit. Ratios of interest lie between about 0.02 and 0.07, so the ratio output resolves 2^-24.

Each channel closes its window, snapshots its accumulators, and restarts accumulating at once. A sequential stage then forms N·Σx² − (Σx)², takes a bit-serial integer square root and divides by N. Results come out with a one-cycle done pulse and are held until that channel's next window completes.

Top module: `spr_stats`

## Requirements
- R1: A channel's window closes in the first idle cycle in which its count of accepted samples is at least `win_target`; the reported `res_count` equals the number of samples in the closed window.
- R2: `res_mean` is the window sum divided by the count, truncated toward zero, as a signed 16-bit value.
- R3: `res_std` is unsigned with 8 fraction bits and equals floor(256·sqrt(N·Σx² − (Σx)²) / N), the population standard deviation.
- R4: `res_ratio` is unsigned Q0.24 and equals floor(res_std · `ratio_k` / 2^14), with `ratio_k` unsigned Q2.30; values above 2^24−1 saturate to 2^24−1.
- R5: `res_done` for a channel is high for exactly one cycle per closed window, a fixed number of cycles after the window's last sample whatever the data; the result outputs change only in that cycle.
- R6: Samples accepted while a channel is computing are counted into its next window.
- R7: A one-cycle `sync_clear` empties both channels' accumulators, discards any sample present in that cycle, abandons any computation in progress without a done pulse, and leaves the held results unchanged.
- R8: A window that closes with zero samples (possible only with `win_target` = 0) reports mean, deviation, ratio and count of zero with `res_invalid` = 1; any other window reports `res_invalid` = 0.
- R9: The channels are independent: samples on one channel never change the other's count, timing or results.
- R10: During and after reset, before any window closes, all result outputs, `res_done` and `res_invalid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_clear | input | 1 | Empties both channels' accumulators and restarts their windows |
| win_target | input | CNT_W (13) | Samples per window, shared by both channels |
| ratio_k | input | SCALE_W (32) | Ratio scaling constant, unsigned Q2.30 |
| smp_valid | input | N_CH (2) | Per-channel sample strobe |
| smp_data | input | N_CH*16 | Per-channel signed samples, channel 0 in the low bits |
| res_done | output | N_CH | One-cycle result pulse per channel |
| res_invalid | output | N_CH | Set when the reported window held no samples |
| res_mean | output | N_CH*16 | Signed mean per channel |
| res_std | output | N_CH*24 | Standard deviation, 8 fraction bits |
| res_ratio | output | N_CH*24 | Switched-power ratio, Q0.24 |
| res_count | output | N_CH*CNT_W | Samples in the reported window |

## Verification
A channel's results appear together with its done pulse about 80 cycles after the window's last accepted sample: one cycle to close, one to form the variance numerator, and two serial passes of 37 steps each for the root and the division. The latency does not depend on the data, so the bench polls each channel's done bit on falling edges within a bounded wait. It reads the outputs in the cycle where the bit is seen, checks the pulse is gone one cycle later, and requires every full-window latency to equal the first one it measured. Hold behaviour and the absence of pulses after a clear are checked by watching the outputs for a fixed stretch of cycles.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_ROOT,
    ST_DIV,
    ST_OUT
  } spr_state_e;
endpackage

// File: rtl/spr_udiv.sv
module spr_udiv #(
  parameter int NUM_W = 29,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [CW-1:0]    left;
  logic             run;
  logic [DEN_W:0]   shf;
  logic [DEN_W:0]   dif;
  logic             take;

  assign shf  = {rem, quo[NUM_W-1]};
  assign dif  = shf - {1'b0, den};
  assign take = shf >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quo  <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quo  <= num;
        left <= CW'(NUM_W);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= take ? dif[DEN_W-1:0] : shf[DEN_W-1:0];
        quo  <= {quo[NUM_W-2:0], take};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2/R3: partial remainder always stays below the divisor
  p_rem_below_den_r2: assert property (@(posedge clk) disable iff (rst)
    (run && den != '0) |-> (rem < den));
endmodule

// File: rtl/spr_isqrt.sv
module spr_isqrt #(
  parameter int RAD_W = 74
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [RAD_W-1:0]     rad,
  output logic [RAD_W/2-1:0]   root,
  output logic                 done
);
  localparam int RT_W = RAD_W / 2;
  localparam int RW   = RT_W + 1;
  localparam int CW   = $clog2(RT_W + 1);

  logic [RAD_W-1:0] sh;
  logic [RW-1:0]    rem;
  logic [CW-1:0]    left;
  logic             run;
  logic [RT_W+2:0]  rsh;
  logic [RT_W+2:0]  trial;
  logic [RT_W+2:0]  dif;
  logic             fit;

  assign rsh   = {rem, sh[RAD_W-1 -: 2]};
  assign trial = {1'b0, root, 2'b01};
  assign dif   = rsh - trial;
  assign fit   = rsh >= trial;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rem  <= '0;
      root <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh   <= rad;
        rem  <= '0;
        root <= '0;
        left <= CW'(RT_W);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= fit ? dif[RW-1:0] : rsh[RW-1:0];
        root <= {root[RT_W-2:0], fit};
        sh   <= {sh[RAD_W-3:0], 2'b00};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: restoring invariant, remainder never exceeds twice the partial root
  p_root_rem_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem <= {root, 1'b0}));
endmodule

// File: rtl/spr_chan.sv
module spr_chan
  import spr_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int CNT_W      = 13,
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 30,
  parameter int FRAC_W     = 8,
  parameter int RATIO_W    = 24
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic [CNT_W-1:0]             target,
  input  logic [SCALE_W-1:0]           scale,
  input  logic                         s_valid,
  input  logic signed [SAMPLE_W-1:0]   s_data,
  output logic                         done,
  output logic                         invalid,
  output logic signed [SAMPLE_W-1:0]   mean,
  output logic [SAMPLE_W+FRAC_W-1:0]   std,
  output logic [RATIO_W-1:0]           ratio,
  output logic [CNT_W-1:0]             count
);
  localparam int SUM_W  = SAMPLE_W + CNT_W;
  localparam int SQ_W   = 2 * SAMPLE_W + CNT_W;
  localparam int D_W    = 2 * SUM_W;
  localparam int RAD_W  = D_W + 2 * FRAC_W;
  localparam int RT_W   = RAD_W / 2;
  localparam int STD_W  = SAMPLE_W + FRAC_W;
  localparam int PROD_W = STD_W + SCALE_W;
  localparam int SHIFT  = FRAC_W + SCALE_FRAC - RATIO_W;
  localparam logic [PROD_W-1:0] SAT = PROD_W'({RATIO_W{1'b1}});

  spr_state_e state;

  // running accumulators
  logic [CNT_W-1:0]               a_cnt;
  logic signed [SUM_W-1:0]        a_sum;
  logic [SQ_W-1:0]                a_sq;
  logic signed [2*SAMPLE_W-1:0]   x_sq;
  logic signed [SUM_W-1:0]        x_ext;
  logic [SQ_W-1:0]                x_sq_ext;
  logic                           close;

  assign x_sq     = s_data * s_data;
  assign x_ext    = SUM_W'(s_data);
  assign x_sq_ext = SQ_W'($unsigned(x_sq));
  assign close    = (state == ST_IDLE) && (a_cnt >= target);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      a_cnt <= '0;
      a_sum <= '0;
      a_sq  <= '0;
    end else if (close) begin
      a_cnt <= s_valid ? CNT_W'(1) : '0;
      a_sum <= s_valid ? x_ext : '0;
      a_sq  <= s_valid ? x_sq_ext : '0;
    end else if (s_valid) begin
      a_cnt <= a_cnt + 1'b1;
      a_sum <= a_sum + x_ext;
      a_sq  <= a_sq + x_sq_ext;
    end
  end

  // window snapshot and arithmetic
  logic [CNT_W-1:0]         n_r;
  logic signed [SUM_W-1:0]  s_r;
  logic [SQ_W-1:0]          q_r;
  logic [D_W-1:0]           d_r;
  logic [D_W-1:0]           nq;
  logic signed [D_W-1:0]    ssq;
  logic [SUM_W-1:0]         s_mag;
  logic                     go_root;
  logic                     go_div;
  logic                     sub_rst;

  assign nq      = D_W'(n_r) * D_W'(q_r);
  assign ssq     = s_r * s_r;
  assign s_mag   = s_r[SUM_W-1] ? $unsigned(-s_r) : $unsigned(s_r);
  assign sub_rst = rst || clear;

  logic [RT_W-1:0]  rt_val;
  logic             rt_done;
  logic [RT_W-1:0]  sd_quo;
  logic             sd_done;
  logic [SUM_W-1:0] md_quo;
  logic             md_done;

  spr_isqrt #(.RAD_W(RAD_W)) u_root (
    .clk  (clk),
    .rst  (sub_rst),
    .start(go_root),
    .rad  ({d_r, {(2*FRAC_W){1'b0}}}),
    .root (rt_val),
    .done (rt_done)
  );

  spr_udiv #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_mdiv (
    .clk  (clk),
    .rst  (sub_rst),
    .start(go_root),
    .num  (s_mag),
    .den  (n_r),
    .quo  (md_quo),
    .done (md_done)
  );

  spr_udiv #(.NUM_W(RT_W), .DEN_W(CNT_W)) u_sdiv (
    .clk  (clk),
    .rst  (sub_rst),
    .start(go_div),
    .num  (rt_val),
    .den  (n_r),
    .quo  (sd_quo),
    .done (sd_done)
  );

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] prod_sh;
  assign prod    = PROD_W'(sd_quo[STD_W-1:0]) * PROD_W'(scale);
  assign prod_sh = prod >> SHIFT;

  logic md_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      n_r     <= '0;
      s_r     <= '0;
      q_r     <= '0;
      d_r     <= '0;
      go_root <= 1'b0;
      go_div  <= 1'b0;
      md_seen <= 1'b0;
      done    <= 1'b0;
      invalid <= 1'b0;
      mean    <= '0;
      std     <= '0;
      ratio   <= '0;
      count   <= '0;
    end else begin
      go_root <= 1'b0;
      go_div  <= 1'b0;
      done    <= 1'b0;
      if (md_done) md_seen <= 1'b1;
      if (clear) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (close) begin
            n_r   <= a_cnt;
            s_r   <= a_sum;
            q_r   <= a_sq;
            state <= ST_MUL;
          end
          ST_MUL: if (n_r == '0) begin
            mean    <= '0;
            std     <= '0;
            ratio   <= '0;
            count   <= '0;
            invalid <= 1'b1;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            d_r     <= nq - $unsigned(ssq);
            go_root <= 1'b1;
            md_seen <= 1'b0;
            state   <= ST_ROOT;
          end
          ST_ROOT: if (rt_done) begin
            go_div <= 1'b1;
            state  <= ST_DIV;
          end
          ST_DIV: if (sd_done) state <= ST_OUT;
          ST_OUT: begin
            mean    <= s_r[SUM_W-1] ? -SAMPLE_W'(md_quo) : SAMPLE_W'(md_quo);
            std     <= sd_quo[STD_W-1:0];
            ratio   <= (prod_sh > SAT) ? {RATIO_W{1'b1}} : prod_sh[RATIO_W-1:0];
            count   <= n_r;
            invalid <= 1'b0;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: a window closes with the live count captured
  p_close_r1: assert property (@(posedge clk) disable iff (rst)
    (close && !clear) |=> (state == ST_MUL) && (n_r == $past(a_cnt)));

  // R3: the variance numerator is never negative
  p_var_nonneg_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MUL && n_r != '0) |-> (nq >= $unsigned(ssq)));

  // R3: deviation quotient fits the output field, mean divider has finished
  p_std_fits_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OUT) |-> (sd_quo[RT_W-1:STD_W] == '0) && md_seen);

  // R5: single-cycle done pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: results only move together with a done pulse
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(mean) && $stable(std) && $stable(ratio) && $stable(count));

  // R7: clear empties the window and suppresses any pulse
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (a_cnt == '0) && !done);

  // R8: an empty window reports zeros
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (done && invalid) |-> (mean == '0) && (std == '0) && (ratio == '0) && (count == '0));
endmodule

// File: rtl/spr_stats.sv
module spr_stats #(
  parameter int N_CH       = 2,
  parameter int SAMPLE_W   = 16,
  parameter int CNT_W      = 13,
  parameter int SCALE_W    = 32,
  parameter int SCALE_FRAC = 30,
  parameter int FRAC_W     = 8,
  parameter int RATIO_W    = 24
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                sync_clear,
  input  logic [CNT_W-1:0]                    win_target,
  input  logic [SCALE_W-1:0]                  ratio_k,
  input  logic [N_CH-1:0]                     smp_valid,
  input  logic [N_CH*SAMPLE_W-1:0]            smp_data,
  output logic [N_CH-1:0]                     res_done,
  output logic [N_CH-1:0]                     res_invalid,
  output logic [N_CH*SAMPLE_W-1:0]            res_mean,
  output logic [N_CH*(SAMPLE_W+FRAC_W)-1:0]   res_std,
  output logic [N_CH*RATIO_W-1:0]             res_ratio,
  output logic [N_CH*CNT_W-1:0]               res_count
);
  localparam int STD_W = SAMPLE_W + FRAC_W;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic signed [SAMPLE_W-1:0] mean_c;
    assign res_mean[c*SAMPLE_W +: SAMPLE_W] = mean_c;

    spr_chan #(
      .SAMPLE_W  (SAMPLE_W),
      .CNT_W     (CNT_W),
      .SCALE_W   (SCALE_W),
      .SCALE_FRAC(SCALE_FRAC),
      .FRAC_W    (FRAC_W),
      .RATIO_W   (RATIO_W)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .clear  (sync_clear),
      .target (win_target),
      .scale  (ratio_k),
      .s_valid(smp_valid[c]),
      .s_data (smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .done   (res_done[c]),
      .invalid(res_invalid[c]),
      .mean   (mean_c),
      .std    (res_std[c*STD_W +: STD_W]),
      .ratio  (res_ratio[c*RATIO_W +: RATIO_W]),
      .count  (res_count[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/sim_spr_stats.sv
`timescale 1ns/1ps
module sim_spr_stats;
  logic        clk = 1'b0;
  logic        rst;
  logic        sync_clear;
  logic [12:0] win_target;
  logic [31:0] ratio_k;
  logic [1:0]  smp_valid;
  logic [31:0] smp_data;
  logic [1:0]  res_done;
  logic [1:0]  res_invalid;
  logic [31:0] res_mean;
  logic [47:0] res_std;
  logic [47:0] res_ratio;
  logic [25:0] res_count;

  always #2.5 clk = ~clk;

  spr_stats u0 (
    .clk(clk), .rst(rst), .sync_clear(sync_clear), .win_target(win_target),
    .ratio_k(ratio_k), .smp_valid(smp_valid), .smp_data(smp_data),
    .res_done(res_done), .res_invalid(res_invalid), .res_mean(res_mean),
    .res_std(res_std), .res_ratio(res_ratio), .res_count(res_count)
  );

  // stimulus table: count, base, step, period, ratio constant
  localparam int TBL [0:5][0:4] = '{
    '{100,  1000,    40, 20,    2684355},
    '{64,  -5000,   200,  8,    1000000},
    '{50,      0,     0, 10,    2684355},
    '{37, -32768, 65535,  6,        100},
    '{120,   300,     7, 50, 1073741824},
    '{1,   12345,     0,  2,       5000}
  };

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int smp [0:1][0:1023];
  int ns [0:1];

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic longint g_mean(int ch);
    return longint'($signed(res_mean[ch*16 +: 16]));
  endfunction
  function automatic longint g_std(int ch);
    return longint'(res_std[ch*24 +: 24]);
  endfunction
  function automatic longint g_ratio(int ch);
    return longint'(res_ratio[ch*24 +: 24]);
  endfunction
  function automatic longint g_cnt(int ch);
    return longint'(res_count[ch*13 +: 13]);
  endfunction

  task automatic send(input logic v0, input int x0, input logic v1, input int x1);
    @(negedge clk);
    smp_valid = {v1, v0};
    smp_data  = {16'(x1), 16'(x0)};
    if (v0) begin smp[0][ns[0]] = x0; ns[0]++; end
    if (v1) begin smp[1][ns[1]] = x1; ns[1]++; end
    @(negedge clk);
    smp_valid = 2'b00;
  endtask

  task automatic wait_done(input logic [1:0] mask, output logic [1:0] seen, output int cyc);
    cyc = 0;
    while (((res_done & mask) == 2'b00) && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    seen = res_done;
  endtask

  task automatic model(input int ch, input longint k,
                       output longint e_mean, output longint e_std, output longint e_ratio);
    longint s = 0;
    longint q = 0;
    longint n;
    logic [127:0] d, rad, r, cand, prod;
    n = ns[ch];
    for (int i = 0; i < n; i++) begin
      s += smp[ch][i];
      q += longint'(smp[ch][i]) * smp[ch][i];
    end
    if (n == 0) begin
      e_mean = 0; e_std = 0; e_ratio = 0;
    end else begin
      e_mean = s / n;
      d   = 128'(n * q - s * s);
      rad = d << 16;
      r   = 0;
      for (int b = 40; b >= 0; b--) begin
        cand = r | (128'(1) << b);
        if (cand * cand <= rad) r = cand;
      end
      e_std = longint'(r / 128'(n));
      prod  = (128'(e_std) * 128'(k)) >> 14;
      e_ratio = (prod > 128'(16777215)) ? 16777215 : longint'(prod);
    end
  endtask

  task automatic check_ch(input int ch, input longint k, input string tg);
    longint em, es, er;
    model(ch, k, em, es, er);
    chk({"R1 count ", tg}, g_cnt(ch), ns[ch]);
    chk({"R2 mean ", tg}, g_mean(ch), em);
    chk({"R3 std ", tg}, g_std(ch), es);
    chk({"R4 ratio ", tg}, g_ratio(ch), er);
    chk({"R8 invalid low ", tg}, longint'(res_invalid[ch]), 0);
  endtask

  // watchdog
  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] seen;
    int cyc;
    int lat0;
    longint hm, hs, hr, hc;
    rst = 1'b1; sync_clear = 1'b0; win_target = 13'd4000;
    ratio_k = 32'd0; smp_valid = 2'b00; smp_data = '0;
    ns[0] = 0; ns[1] = 0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 done", longint'(res_done), 0);
    chk("R10 invalid", longint'(res_invalid), 0);
    chk("R10 ratio", longint'(res_ratio), 0);
    chk("R10 count", longint'(res_count), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 mean after reset", longint'(res_mean), 0);

    // table walk
    lat0 = -1;
    for (int t = 0; t < 6; t++) begin
      win_target = 13'(TBL[t][0]);
      ratio_k = 32'(TBL[t][4]);
      ns[0] = 0; ns[1] = 0;
      for (int j = 0; j < TBL[t][0]; j++) begin
        int x0, x1;
        x0 = TBL[t][1] + (((j % TBL[t][3]) < TBL[t][3] / 2) ? TBL[t][2] : 0);
        x1 = -(x0 / 2) + (j % 7);
        send(1'b1, x0, 1'b1, x1);
      end
      wait_done(2'b11, seen, cyc);
      chk($sformatf("R9 both done entry %0d", t), longint'(seen), 3);
      if (lat0 < 0) lat0 = cyc;
      chk($sformatf("R5 fixed latency entry %0d", t), cyc, lat0);
      check_ch(0, TBL[t][4], $sformatf("ch0 entry %0d", t));
      check_ch(1, TBL[t][4], $sformatf("ch1 entry %0d", t));
      @(negedge clk);
      chk($sformatf("R5 pulse width entry %0d", t), longint'(res_done), 0);
    end

    // R5: held results
    hm = g_mean(0); hs = g_std(0); hr = g_ratio(0); hc = g_cnt(0);
    cyc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (res_done != 2'b00) cyc++;
    end
    chk("R5 no spurious done", cyc, 0);
    chk("R5 mean held", g_mean(0), hm);
    chk("R5 count held", g_cnt(0), hc);

    // R6 and R9: late samples, single channel
    win_target = 13'd20; ratio_k = 32'd2684355;
    ns[0] = 0; ns[1] = 0;
    for (int j = 0; j < 20; j++) send(1'b1, 500 + 30 * (j % 2), 1'b0, 0);
    begin
      longint em, es, er;
      model(0, 2684355, em, es, er);
      ns[0] = 0;
      for (int j = 0; j < 3; j++) send(1'b1, -700 + j, 1'b0, 0);
      wait_done(2'b01, seen, cyc);
      chk("R9 only ch0 done", longint'(seen), 1);
      chk("R6 first window count", g_cnt(0), 20);
      chk("R6 first window mean", g_mean(0), em);
      chk("R6 first window std", g_std(0), es);
    end
    hm = g_mean(1); hc = g_cnt(1);
    for (int j = 0; j < 17; j++) send(1'b1, 200 - 11 * j, 1'b0, 0);
    wait_done(2'b01, seen, cyc);
    check_ch(0, 2684355, "R6 late samples in next window");
    chk("R9 ch1 mean untouched", g_mean(1), hm);
    chk("R9 ch1 count untouched", g_cnt(1), hc);
    for (int j = 0; j < 20; j++) send(1'b0, 0, 1'b1, 9 * j - 40);
    wait_done(2'b10, seen, cyc);
    chk("R9 only ch1 done", longint'(seen), 2);
    check_ch(1, 2684355, "R9 ch1 own window");

    // R7: clear mid-accumulation
    win_target = 13'd10;
    repeat (100) @(negedge clk);
    ns[0] = 0;
    for (int j = 0; j < 6; j++) send(1'b1, 9000, 1'b0, 0);
    @(negedge clk);
    sync_clear = 1'b1;
    smp_valid = 2'b01; smp_data = {16'd0, 16'd8000};
    @(negedge clk);
    sync_clear = 1'b0; smp_valid = 2'b00;
    ns[0] = 0;
    for (int j = 0; j < 10; j++) send(1'b1, -100 + 3 * j * j, 1'b0, 0);
    wait_done(2'b01, seen, cyc);
    check_ch(0, 2684355, "R7 clear drops old samples");

    // R7: clear during computation
    hm = g_mean(0); hs = g_std(0); hc = g_cnt(0);
    ns[0] = 0;
    for (int j = 0; j < 10; j++) send(1'b1, 4000, 1'b0, 0);
    repeat (20) @(negedge clk);
    sync_clear = 1'b1;
    @(negedge clk);
    sync_clear = 1'b0;
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (res_done != 2'b00) cyc++;
    end
    chk("R7 aborted window no done", cyc, 0);
    chk("R7 mean held after clear", g_mean(0), hm);
    chk("R7 std held after clear", g_std(0), hs);
    chk("R7 count held after clear", g_cnt(0), hc);

    // R8: empty window
    win_target = 13'd0;
    wait_done(2'b01, seen, cyc);
    chk("R8 empty invalid", longint'(res_invalid[0]), 1);
    chk("R8 empty mean", g_mean(0), 0);
    chk("R8 empty std", g_std(0), 0);
    chk("R8 empty ratio", g_ratio(0), 0);
    chk("R8 empty count", g_cnt(0), 0);
    @(negedge clk);
    win_target = 13'd5;
    repeat (20) @(negedge clk);
    ns[0] = 0;
    for (int j = 0; j < 5; j++) send(1'b1, 77 * j, 1'b0, 0);
    wait_done(2'b01, seen, cyc);
    check_ch(0, 2684355, "R8 valid after empty");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule